// File: doc/BRIEF.md
# Arithmetic Status Flag Register

This block is a 16-bit processor status word. It derives the arithmetic condition flags from an add or subtract of two operands, and it holds three control bits. The datapath presents two operands, selects add or subtract, and selects byte or word width. When it raises the update strobe, the register captures carry, parity, auxiliary carry, zero, sign and overflow for that operation.

The trap, interrupt-enable and direction bits are controlled only through their own set and clear strobes, so arithmetic updates never disturb them. The direction bit tells the string-address logic which way to move. A value of 1 makes index offsets step downward after each element, and 0 makes them step upward.

The full flag word and each individual flag are outputs. Reserved positions read as constants.

Top module: `status_word_reg`

## Requirements
- R1: While reset is held, and after it is released with no strobe, the flag word reads 16'h0002, with every flag and control output at 0.
- R2: Bit 0 (carry) is set on an add that carries out of the top bit of the active width. On a subtract it is set when a borrow occurs, which is when operand A is unsigned less than operand B.
- R3: Bit 2 (parity) is set when the low 8 bits of the result contain an even number of ones. This holds for both byte and word width.
- R4: Bit 4 (auxiliary) is set on an add that carries out of bit 3, or on a subtract that borrows into bit 3.
- R5: Bit 6 (zero) is set when the result, masked to the active width, equals zero.
- R6: Bit 7 (sign) equals the top bit of the result at the active width: bit 7 for byte width, bit 15 for word width.
- R7: Bit 11 (overflow) is set when the signed result at the active width cannot be represented.
- R8: The arithmetic flags load on the rising clock edge at which upd_stb is 1, and are visible once that edge has passed. While upd_stb is 0 they hold their value, whatever the operands are.
- R9: Bits 8 (trap), 9 (interrupt enable) and 10 (direction) are each set by their set strobe and cleared by their clear strobe. If both strobes are high, set wins. With no strobe the bit holds. upd_stb never changes these bits, and the control strobes never change the arithmetic flags.
- R10: Bit 1 always reads 1. Bits 3, 5 and 12 to 15 always read 0.
- R11: In byte mode (byte_sel = 1), bits 15 to 8 of both operands have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_a | input | 16 | First operand (minuend on subtract) |
| opnd_b | input | 16 | Second operand (subtrahend on subtract) |
| sub_sel | input | 1 | 1 = subtract, 0 = add |
| byte_sel | input | 1 | 1 = byte width, 0 = word width |
| upd_stb | input | 1 | Capture the arithmetic flags this cycle |
| trap_set | input | 1 | Set the trap bit |
| trap_clr | input | 1 | Clear the trap bit |
| ien_set | input | 1 | Set the interrupt-enable bit |
| ien_clr | input | 1 | Clear the interrupt-enable bit |
| dir_set | input | 1 | Set the direction bit |
| dir_clr | input | 1 | Clear the direction bit |
| flag_word | output | 16 | Full status word |
| cf | output | 1 | Carry / borrow |
| pf | output | 1 | Even parity of the low byte |
| af | output | 1 | Auxiliary carry / borrow |
| zf | output | 1 | Zero result |
| sf | output | 1 | Sign of result |
| tf | output | 1 | Trap enable |
| ief | output | 1 | Interrupt enable |
| df | output | 1 | Direction |
| of | output | 1 | Signed overflow |

## Verification
Every result passes through exactly one register. Arithmetic flags driven with upd_stb appear one edge later, and control-bit strobes likewise take effect one edge later. The bench changes inputs on the falling edge and reads the outputs on the next falling edge, half a period after the capturing edge.

After each update, an idle cycle with fresh operands confirms that the flags held (R8). Each control strobe is followed by a read of the arithmetic bits, to confirm that they did not move.

// File: rtl/status_word_pkg.sv
package status_word_pkg;
   localparam int FLAG_W = 16;
   localparam int POS_CF = 0;
   localparam int POS_PF = 2;
   localparam int POS_AF = 4;
   localparam int POS_ZF = 6;
   localparam int POS_SF = 7;
   localparam int POS_TF = 8;
   localparam int POS_IF = 9;
   localparam int POS_DF = 10;
   localparam int POS_OF = 11;
   localparam int CTL_N  = 3;
   localparam logic [FLAG_W-1:0] FIXED_ONES = 16'h0002;

   typedef struct packed {
      logic ovf;
      logic sgn;
      logic zro;
      logic aux;
      logic par;
      logic cry;
   } arith_flags_t;
endpackage

// File: rtl/sw_addsub.sv
module sw_addsub #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] sum_o,
   output logic [DATA_W:0]   carry_o
);
   logic [DATA_W-1:0] b_eff;
   logic [DATA_W:0]   ext;

   always_comb begin
      b_eff   = sub_i ? ~b_i : b_i;
      ext     = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
      sum_o   = ext[DATA_W-1:0];
      // carry_o[i] is the carry into bit i; carry_o[DATA_W] is the top carry out
      carry_o = ext ^ {1'b0, a_i} ^ {1'b0, b_eff};
   end
endmodule

// File: rtl/sw_flag_calc.sv
module sw_flag_calc
   import status_word_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8,
   parameter int NIB_W    = 4,
   parameter int PAR_W    = 8
) (
   input  logic [DATA_W-1:0] sum_i,
   input  logic [DATA_W:0]   carry_i,
   input  logic              sub_i,
   input  logic              narrow_i,
   output arith_flags_t      flags_o
);
   logic c_out;
   logic c_msb_in;
   logic msb;
   logic is_zero;

   generate
      if (NARROW_W == DATA_W) begin : g_single_lane
         always_comb begin
            c_out    = carry_i[DATA_W];
            c_msb_in = carry_i[DATA_W-1];
            msb      = sum_i[DATA_W-1];
            is_zero  = (sum_i == '0);
         end
      end else begin : g_dual_lane
         always_comb begin
            if (narrow_i) begin
               c_out    = carry_i[NARROW_W];
               c_msb_in = carry_i[NARROW_W-1];
               msb      = sum_i[NARROW_W-1];
               is_zero  = (sum_i[NARROW_W-1:0] == '0);
            end else begin
               c_out    = carry_i[DATA_W];
               c_msb_in = carry_i[DATA_W-1];
               msb      = sum_i[DATA_W-1];
               is_zero  = (sum_i == '0);
            end
         end
      end
   endgenerate

   always_comb begin
      flags_o.cry = c_out ^ sub_i;
      flags_o.aux = carry_i[NIB_W] ^ sub_i;
      flags_o.ovf = c_out ^ c_msb_in;
      flags_o.sgn = msb;
      flags_o.zro = is_zero;
      flags_o.par = ~^sum_i[PAR_W-1:0];
   end
endmodule

// File: rtl/sw_ctl_bit.sv
module sw_ctl_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end
endmodule

// File: rtl/status_word_reg.sv
module status_word_reg
   import status_word_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8,
   parameter int NIB_W    = 4,
   parameter int PAR_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic              sub_sel,
   input  logic              byte_sel,
   input  logic              upd_stb,
   input  logic              trap_set,
   input  logic              trap_clr,
   input  logic              ien_set,
   input  logic              ien_clr,
   input  logic              dir_set,
   input  logic              dir_clr,
   output logic [FLAG_W-1:0] flag_word,
   output logic              cf,
   output logic              pf,
   output logic              af,
   output logic              zf,
   output logic              sf,
   output logic              tf,
   output logic              ief,
   output logic              df,
   output logic              of
);
   generate
      if (NARROW_W > DATA_W || NARROW_W < 2) begin : g_bad_narrow
         $error("status_word_reg: NARROW_W must lie in 2..DATA_W");
      end
      if (NIB_W < 1 || NIB_W >= NARROW_W) begin : g_bad_nib
         $error("status_word_reg: NIB_W must lie in 1..NARROW_W-1");
      end
      if (PAR_W < 1 || PAR_W > NARROW_W) begin : g_bad_par
         $error("status_word_reg: PAR_W must lie in 1..NARROW_W");
      end
   endgenerate

   logic [DATA_W-1:0] sum;
   logic [DATA_W:0]   carries;
   arith_flags_t      nxt_flags;
   arith_flags_t      st_q;
   logic [CTL_N-1:0]  ctl_set;
   logic [CTL_N-1:0]  ctl_clr;
   logic [CTL_N-1:0]  ctl_q;

   sw_addsub #(.DATA_W(DATA_W)) u_addsub (
      .a_i     (opnd_a),
      .b_i     (opnd_b),
      .sub_i   (sub_sel),
      .sum_o   (sum),
      .carry_o (carries)
   );

   sw_flag_calc #(
      .DATA_W   (DATA_W),
      .NARROW_W (NARROW_W),
      .NIB_W    (NIB_W),
      .PAR_W    (PAR_W)
   ) u_calc (
      .sum_i    (sum),
      .carry_i  (carries),
      .sub_i    (sub_sel),
      .narrow_i (byte_sel),
      .flags_o  (nxt_flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       st_q <= '0;
      else if (upd_stb) st_q <= nxt_flags;
   end

   assign ctl_set = {dir_set, ien_set, trap_set};
   assign ctl_clr = {dir_clr, ien_clr, trap_clr};

   generate
      for (genvar i = 0; i < CTL_N; i++) begin : g_ctl
         sw_ctl_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (ctl_set[i]),
            .clr_i (ctl_clr[i]),
            .q_o   (ctl_q[i])
         );
      end
   endgenerate

   always_comb begin
      flag_word         = FIXED_ONES;
      flag_word[POS_CF] = st_q.cry;
      flag_word[POS_PF] = st_q.par;
      flag_word[POS_AF] = st_q.aux;
      flag_word[POS_ZF] = st_q.zro;
      flag_word[POS_SF] = st_q.sgn;
      flag_word[POS_TF] = ctl_q[0];
      flag_word[POS_IF] = ctl_q[1];
      flag_word[POS_DF] = ctl_q[2];
      flag_word[POS_OF] = st_q.ovf;
   end

   assign cf  = flag_word[POS_CF];
   assign pf  = flag_word[POS_PF];
   assign af  = flag_word[POS_AF];
   assign zf  = flag_word[POS_ZF];
   assign sf  = flag_word[POS_SF];
   assign tf  = flag_word[POS_TF];
   assign ief = flag_word[POS_IF];
   assign df  = flag_word[POS_DF];
   assign of  = flag_word[POS_OF];
endmodule

// File: rtl/status_word_reg_chk.sv
module status_word_reg_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        upd_stb,
   input logic        trap_set,
   input logic        trap_clr,
   input logic        ien_set,
   input logic        ien_clr,
   input logic        dir_set,
   input logic        dir_clr,
   input logic [15:0] flag_word
);
   localparam logic [15:0] RSVD_MASK = 16'hF02A;
   localparam logic [15:0] STAT_MASK = 16'h08D5;

   assert_fixed_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_word & RSVD_MASK) == 16'h0002);

   assert_status_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_stb |=> $stable(flag_word & STAT_MASK));

   assert_trap_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trap_set |=> flag_word[8]);

   assert_ien_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ien_set |=> flag_word[9]);

   assert_dir_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_clr && !dir_set) |=> !flag_word[10]);

   assert_ctl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(trap_set || trap_clr || ien_set || ien_clr || dir_set || dir_clr)
      |=> $stable(flag_word[10:8]));

   assert_zero_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
      flag_word[6] |-> flag_word[2]);

   assert_zero_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
      flag_word[6] |-> !flag_word[7]);
endmodule

bind status_word_reg status_word_reg_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .upd_stb   (upd_stb),
   .trap_set  (trap_set),
   .trap_clr  (trap_clr),
   .ien_set   (ien_set),
   .ien_clr   (ien_clr),
   .dir_set   (dir_set),
   .dir_clr   (dir_clr),
   .flag_word (flag_word)
);

// File: tb/status_word_reg_bench.sv
module status_word_reg_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] opnd_a = '0;
   logic [15:0] opnd_b = '0;
   logic        sub_sel = 1'b0;
   logic        byte_sel = 1'b0;
   logic        upd_stb = 1'b0;
   logic        trap_set = 1'b0, trap_clr = 1'b0;
   logic        ien_set = 1'b0, ien_clr = 1'b0;
   logic        dir_set = 1'b0, dir_clr = 1'b0;
   logic [15:0] flag_word;
   logic        cf, pf, af, zf, sf, tf, ief, df, of;

   int checks = 0;
   int errors = 0;
   logic [15:0] m_stat = '0;
   logic [2:0]  m_ctl = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   status_word_reg u_status_word_reg (
      .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .sub_sel(sub_sel), .byte_sel(byte_sel), .upd_stb(upd_stb),
      .trap_set(trap_set), .trap_clr(trap_clr), .ien_set(ien_set),
      .ien_clr(ien_clr), .dir_set(dir_set), .dir_clr(dir_clr),
      .flag_word(flag_word), .cf(cf), .pf(pf), .af(af), .zf(zf), .sf(sf),
      .tf(tf), .ief(ief), .df(df), .of(of)
   );

   function automatic logic [15:0] model_stat(input logic [15:0] a, input logic [15:0] b,
                                              input logic sub, input logic byt);
      int unsigned mask, aa, bb, r, top;
      logic c, h, o, sa, sb, sr;
      logic [15:0] w;
      mask = byt ? 32'hFF : 32'hFFFF;
      top  = byt ? 7 : 15;
      aa = a & mask;
      bb = b & mask;
      if (sub) begin
         r = (aa - bb) & mask;
         c = aa < bb;
         h = (aa & 15) < (bb & 15);
      end else begin
         r = aa + bb;
         c = r > mask;
         r = r & mask;
         h = ((aa & 15) + (bb & 15)) > 15;
      end
      sa = aa[top];
      sb = bb[top];
      sr = r[top];
      o = sub ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
      w = '0;
      w[0]  = c;
      w[2]  = ~^r[7:0];
      w[4]  = h;
      w[6]  = (r == 0);
      w[7]  = sr;
      w[11] = o;
      return w;
   endfunction

   function automatic logic [15:0] model_word();
      return m_stat | {5'b0, m_ctl, 8'b0} | 16'h0002;
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_word();
      logic [15:0] e;
      e = model_word();
      check("R2 carry",  {15'b0, flag_word[0]},  {15'b0, e[0]});
      check("R3 parity", {15'b0, flag_word[2]},  {15'b0, e[2]});
      check("R4 aux",    {15'b0, flag_word[4]},  {15'b0, e[4]});
      check("R5 zero",   {15'b0, flag_word[6]},  {15'b0, e[6]});
      check("R6 sign",   {15'b0, flag_word[7]},  {15'b0, e[7]});
      check("R7 ovf",    {15'b0, flag_word[11]}, {15'b0, e[11]});
      check("R9 ctl",    {13'b0, flag_word[10:8]}, {13'b0, e[10:8]});
      check("R10 fixed", flag_word & 16'hF02A, 16'h0002);
      check("R1 pins",   {7'b0, of, df, ief, tf, sf, zf, af, pf, cf},
            {7'b0, e[11], e[10], e[9], e[8], e[7], e[6], e[4], e[2], e[0]});
   endtask

   task automatic do_op(input logic [15:0] a, input logic [15:0] b,
                        input logic sub, input logic byt);
      @(negedge clk);
      opnd_a = a; opnd_b = b; sub_sel = sub; byte_sel = byt; upd_stb = 1'b1;
      m_stat = model_stat(a, b, sub, byt);
      @(negedge clk);
      upd_stb = 1'b0;
      check_word();
      // R8: new operands without the strobe leave the flags untouched
      opnd_a = ~a; opnd_b = a ^ b; sub_sel = ~sub;
      @(negedge clk);
      check("R8 hold", flag_word, model_word());
   endtask

   task automatic do_ctl(input logic [2:0] s, input logic [2:0] c);
      @(negedge clk);
      {dir_set, ien_set, trap_set} = s;
      {dir_clr, ien_clr, trap_clr} = c;
      opnd_a = 16'h1234; opnd_b = 16'h4321;
      m_ctl = s | (m_ctl & ~c);
      @(negedge clk);
      {dir_set, ien_set, trap_set} = '0;
      {dir_clr, ien_clr, trap_clr} = '0;
      check("R9 control", flag_word, model_word());
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'd2024;
      void'($urandom(seed));
      #(CLK_PERIOD * 3 + 2);
      check("R1 reset", flag_word, 16'h0002);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R1 after release", flag_word, 16'h0002);

      // directed corners
      do_op(16'h7FFF, 16'h0001, 1'b0, 1'b0);   // R7 word overflow, R6 sign
      do_op(16'h00FF, 16'h0001, 1'b0, 1'b1);   // R2 R4 R5 byte carry to zero
      do_op(16'h0000, 16'h0001, 1'b1, 1'b0);   // R2 borrow word
      do_op(16'h000F, 16'h0001, 1'b0, 1'b0);   // R4 nibble carry
      do_op(16'h8000, 16'h0001, 1'b1, 1'b0);   // R7 subtract overflow
      do_op(16'h0080, 16'h0001, 1'b1, 1'b1);   // R7 byte subtract overflow
      do_op(16'hFF00, 16'h0100, 1'b0, 1'b0);   // R5 word zero, R3 low byte 0
      do_op(16'h1200, 16'h0000, 1'b0, 1'b0);   // R3 parity over low byte only
      // R11: upper bytes in byte mode have no effect
      do_op(16'hAB7F, 16'hCD01, 1'b0, 1'b1);
      check("R11 byte ignore", m_stat, model_stat(16'h007F, 16'h0001, 1'b0, 1'b1));
      do_op(16'h5A10, 16'hA520, 1'b1, 1'b1);

      // control bits
      do_ctl(3'b001, 3'b000);   // trap set
      do_ctl(3'b010, 3'b000);   // interrupt enable set
      do_ctl(3'b100, 3'b100);   // direction: set wins over clear
      do_ctl(3'b000, 3'b011);   // clear trap and interrupt enable
      do_ctl(3'b000, 3'b000);   // hold
      do_op(16'h0001, 16'h0001, 1'b1, 1'b0);  // update keeps control bits
      do_ctl(3'b000, 3'b100);

      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [15:0] ra, rb;
         ra = 16'($urandom);
         rb = 16'($urandom);
         if (($urandom % 8) == 0) rb = ra;
         if (($urandom % 6) == 0) begin
            do_ctl(3'($urandom), 3'($urandom));
         end
         do_op(ra, rb, 1'($urandom), 1'($urandom));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule